// File: doc/BRIEF.md
# LIN-UART Status Flag Collector

This block gathers the one-cycle detection pulses produced around a LIN-capable UART (receiver, transmitter and LIN frame logic) into a single twelve-bit status word, and raises one shared status interrupt request whenever a fresh condition is recorded. Each source is admitted only in the operating mode where it has meaning. Examples are LIN-only checks, checks that apply only in automatic baud rate operation, and checks that need expansion-bit handling. A source pulse outside its mode leaves the word untouched.

Software reads the status word to see which source fired. It writes 1 to a bit to clear that bit. The two activity flags for transmit and receive follow the hardware and are not writable. The data consistency source is computed here: on a compare strobe, the byte being transmitted is checked against the byte read back from the line.

Top module: `lin_uart_stat_collector`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `status_o` and `irq_o` become 0 after that edge.
- R2: A pulse on `par_err_i`, `frm_err_i` or `ovr_err_i` sets status bit 0, 1 or 2 respectively in any mode.
- R3: Status bit 3 (consistency) is set only when `cmp_strobe_i`, `lin_en_i` and `cmp_en_i` are all high and `tx_byte_i` differs from `rx_byte_i`. Equal bytes set nothing.
- R4: Status bit 4 (break field) is set by `brk_rx_i` or by `brk_tx_i` only when `lin_en_i` is high and `rx_mode_i` equals 2'b10.
- R5: Status bits 5 (ID parity), 6 (checksum) and 7 (response preparation) are set by `idpar_err_i`, `csum_err_i` and `rsp_err_i` only when both `lin_en_i` and `auto_baud_i` are high.
- R6: Status bits 8 (ID match) and 9 (expansion bit) are set by `id_match_i` and `ext_bit_i` only when `ext_en_i` is high.
- R7: A write (`wr_en_i` high) clears each bit 0..9 whose `wr_data_i` bit is 1. Bits written with 0 keep their value.
- R8: If a source sets a bit in the same cycle that a write clears it, the bit ends up set.
- R9: Status bits 10 and 11 show `tx_busy_i` and `rx_busy_i` as sampled at the previous clock edge. No write changes them.
- R10: `irq_o` is high for exactly one cycle, in the same cycle that a status bit 0..9 first shows 1 after being 0. A source that fires while its bit is already 1 raises no request.
- R11: With no admitted source pulse and no clearing write, bits 0..9 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| par_err_i | input | 1 | Parity error pulse |
| frm_err_i | input | 1 | Stop-bit-low (framing) pulse |
| ovr_err_i | input | 1 | Overrun pulse |
| cmp_strobe_i | input | 1 | Transmit/read-back compare strobe |
| tx_byte_i | input | DW | Byte being transmitted |
| rx_byte_i | input | DW | Byte read back from the line |
| brk_rx_i | input | 1 | Break field received pulse |
| brk_tx_i | input | 1 | Break field sent by local master pulse |
| idpar_err_i | input | 1 | Identifier parity error pulse |
| csum_err_i | input | 1 | Checksum mismatch pulse |
| rsp_err_i | input | 1 | Response not prepared in time pulse |
| id_match_i | input | 1 | Identifier match pulse |
| ext_bit_i | input | 1 | Expansion bit detected pulse |
| tx_busy_i | input | 1 | Transmitter active level |
| rx_busy_i | input | 1 | Receiver active level |
| lin_en_i | input | 1 | LIN operation enabled |
| auto_baud_i | input | 1 | Automatic baud rate mode |
| rx_mode_i | input | 2 | Reception mode; 2'b10 admits break-field flags |
| cmp_en_i | input | 1 | Consistency check enable |
| ext_en_i | input | 1 | Expansion-bit handling enable |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | NSRC | Write-1-to-clear mask for bits 0..9 |
| status_o | output | NFLAG | Status word |
| irq_o | output | 1 | Status interrupt request pulse |

## Verification
Each status result is due one clock edge after the cycle in which its pulse, write or busy level was presented. The interrupt pulse is due on that same edge and lasts only until the following one. The bench drives stimulus on the falling edge, lets one rising edge pass, and samples shortly after it. It then removes the stimulus and samples again one edge later to confirm that the request has dropped and the flag has held. Gated-off cases are checked by reading the status word after the blocked pulse, before any other stimulus.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int NSRC  = 10;
  localparam int NFLAG = NSRC + 2;

  localparam int B_PAR   = 0;
  localparam int B_FRM   = 1;
  localparam int B_OVR   = 2;
  localparam int B_CMP   = 3;
  localparam int B_BRK   = 4;
  localparam int B_IDPAR = 5;
  localparam int B_CSUM  = 6;
  localparam int B_RSP   = 7;
  localparam int B_IDM   = 8;
  localparam int B_EXT   = 9;
  localparam int B_TXB   = 10;
  localparam int B_RXB   = 11;

  localparam logic [1:0] MODE_BRK_RX = 2'b10;

  typedef logic [NSRC-1:0] src_vec_t;

  // true when the transmitted and read-back bytes disagree in any bit
  function automatic logic bytes_differ(input logic [31:0] a, input logic [31:0] b);
    return |(a ^ b);
  endfunction

  // bits that go from 0 to 1 under a set mask
  function automatic src_vec_t fresh_bits(input src_vec_t set_v, input src_vec_t held_v);
    return set_v & ~held_v;
  endfunction

  // next value of a write-1-to-clear bank where a set beats a clear
  function automatic src_vec_t w1c_next(input src_vec_t held_v, input src_vec_t set_v,
                                        input logic wr, input src_vec_t mask);
    src_vec_t clr_v;
    clr_v = wr ? mask : '0;
    return set_v | (held_v & ~clr_v);
  endfunction
endpackage

// File: rtl/lsc_src_gate.sv
module lsc_src_gate
  import lsc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          par_err_i,
  input  logic          frm_err_i,
  input  logic          ovr_err_i,
  input  logic          cmp_strobe_i,
  input  logic [DW-1:0] tx_byte_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          brk_rx_i,
  input  logic          brk_tx_i,
  input  logic          idpar_err_i,
  input  logic          csum_err_i,
  input  logic          rsp_err_i,
  input  logic          id_match_i,
  input  logic          ext_bit_i,
  input  logic          lin_en_i,
  input  logic          auto_baud_i,
  input  logic [1:0]    rx_mode_i,
  input  logic          cmp_en_i,
  input  logic          ext_en_i,
  output src_vec_t      set_o
);
  // named mode windows, visible to assertions and waveforms
  logic lin_win, abr_win, brk_win, ext_win, cmp_win, mismatch;

  assign lin_win  = lin_en_i;
  assign abr_win  = lin_en_i & auto_baud_i;
  assign brk_win  = lin_en_i & (rx_mode_i == MODE_BRK_RX);
  assign ext_win  = ext_en_i;
  assign cmp_win  = lin_en_i & cmp_en_i;
  assign mismatch = bytes_differ(32'(tx_byte_i), 32'(rx_byte_i));

  always_comb begin
    set_o          = '0;
    set_o[B_PAR]   = par_err_i;
    set_o[B_FRM]   = frm_err_i;
    set_o[B_OVR]   = ovr_err_i;
    set_o[B_CMP]   = cmp_win & cmp_strobe_i & mismatch;
    set_o[B_BRK]   = brk_win & (brk_rx_i | brk_tx_i);
    set_o[B_IDPAR] = abr_win & idpar_err_i;
    set_o[B_CSUM]  = abr_win & csum_err_i;
    set_o[B_RSP]   = abr_win & rsp_err_i;
    set_o[B_IDM]   = ext_win & id_match_i;
    set_o[B_EXT]   = ext_win & ext_bit_i;
  end

  always_comb begin
    AST_LIN_ONLY: assert (lin_win || set_o[B_BRK:B_CMP] == '0); // R3
  end
endmodule

// File: rtl/lsc_flag_bank.sv
module lsc_flag_bank
  import lsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t set_i,
  input  logic     wr_en_i,
  input  src_vec_t wr_data_i,
  input  logic     tx_busy_i,
  input  logic     rx_busy_i,
  output src_vec_t flags_o,
  output logic     tx_busy_o,
  output logic     rx_busy_o
);
  src_vec_t flag_d;

  assign flag_d = w1c_next(flags_o, set_i, wr_en_i, wr_data_i);

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) flags_o[i] <= 1'b0;
        else     flags_o[i] <= flag_d[i];
      end

      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i[i] && !set_i[i]) |=> !flags_o[i]); // R7
      AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i[i] |=> flags_o[i]); // R8
      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!set_i[i] && !(wr_en_i && wr_data_i[i])) |=> $stable(flags_o[i])); // R11
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_busy_o <= 1'b0;
      rx_busy_o <= 1'b0;
    end else begin
      tx_busy_o <= tx_busy_i;
      rx_busy_o <= rx_busy_i;
    end
  end

  AST_BUSY_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tx_busy_o == $past(tx_busy_i)) && (rx_busy_o == $past(rx_busy_i))); // R9
endmodule

// File: rtl/lsc_irq_pulse.sv
module lsc_irq_pulse
  import lsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t set_i,
  input  src_vec_t flags_i,
  output logic     irq_o
);
  logic any_fresh;

  assign any_fresh = |fresh_bits(set_i, flags_i);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= any_fresh;
  end

  AST_IRQ_HAS_RISE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((flags_i & ~$past(flags_i)) != '0)); // R10
endmodule

// File: rtl/lin_uart_stat_collector.sv
module lin_uart_stat_collector
  import lsc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             par_err_i,
  input  logic             frm_err_i,
  input  logic             ovr_err_i,
  input  logic             cmp_strobe_i,
  input  logic [DW-1:0]    tx_byte_i,
  input  logic [DW-1:0]    rx_byte_i,
  input  logic             brk_rx_i,
  input  logic             brk_tx_i,
  input  logic             idpar_err_i,
  input  logic             csum_err_i,
  input  logic             rsp_err_i,
  input  logic             id_match_i,
  input  logic             ext_bit_i,
  input  logic             tx_busy_i,
  input  logic             rx_busy_i,
  input  logic             lin_en_i,
  input  logic             auto_baud_i,
  input  logic [1:0]       rx_mode_i,
  input  logic             cmp_en_i,
  input  logic             ext_en_i,
  input  logic             wr_en_i,
  input  logic [NSRC-1:0]  wr_data_i,
  output logic [NFLAG-1:0] status_o,
  output logic             irq_o
);
  src_vec_t src_set;
  src_vec_t flags_q;
  logic     tx_busy_q, rx_busy_q;

  lsc_src_gate #(.DW(DW)) u_gate (
    .par_err_i   (par_err_i),
    .frm_err_i   (frm_err_i),
    .ovr_err_i   (ovr_err_i),
    .cmp_strobe_i(cmp_strobe_i),
    .tx_byte_i   (tx_byte_i),
    .rx_byte_i   (rx_byte_i),
    .brk_rx_i    (brk_rx_i),
    .brk_tx_i    (brk_tx_i),
    .idpar_err_i (idpar_err_i),
    .csum_err_i  (csum_err_i),
    .rsp_err_i   (rsp_err_i),
    .id_match_i  (id_match_i),
    .ext_bit_i   (ext_bit_i),
    .lin_en_i    (lin_en_i),
    .auto_baud_i (auto_baud_i),
    .rx_mode_i   (rx_mode_i),
    .cmp_en_i    (cmp_en_i),
    .ext_en_i    (ext_en_i),
    .set_o       (src_set)
  );

  lsc_flag_bank u_bank (
    .clk      (clk),
    .rst      (rst),
    .set_i    (src_set),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .tx_busy_i(tx_busy_i),
    .rx_busy_i(rx_busy_i),
    .flags_o  (flags_q),
    .tx_busy_o(tx_busy_q),
    .rx_busy_o(rx_busy_q)
  );

  lsc_irq_pulse u_irq (
    .clk    (clk),
    .rst    (rst),
    .set_i  (src_set),
    .flags_i(flags_q),
    .irq_o  (irq_o)
  );

  assign status_o = {rx_busy_q, tx_busy_q, flags_q};

  AST_ABR_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[B_IDPAR]) |-> $past(lin_en_i && auto_baud_i)); // R5
  AST_BRK_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[B_BRK]) |-> $past(lin_en_i && rx_mode_i == MODE_BRK_RX)); // R4
  AST_EXT_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[B_IDM]) |-> $past(ext_en_i)); // R6
  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (status_o == '0 && !irq_o)); // R1
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> (!irq_o || $past(|fresh_bits(src_set, flags_q)))); // R10
endmodule

// File: tb/test_lin_uart_stat_collector.sv
module test_lin_uart_stat_collector;
  logic clk = 1'b0;
  logic rst;
  logic par_err_i, frm_err_i, ovr_err_i, cmp_strobe_i;
  logic [7:0] tx_byte_i, rx_byte_i;
  logic brk_rx_i, brk_tx_i, idpar_err_i, csum_err_i, rsp_err_i, id_match_i, ext_bit_i;
  logic tx_busy_i, rx_busy_i, lin_en_i, auto_baud_i, cmp_en_i, ext_en_i, wr_en_i;
  logic [1:0] rx_mode_i;
  logic [9:0] wr_data_i;
  logic [11:0] status_o;
  logic irq_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lin_uart_stat_collector #(.DW(8)) i_lin_uart_stat_collector (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_pulses();
    par_err_i = 0; frm_err_i = 0; ovr_err_i = 0; cmp_strobe_i = 0;
    brk_rx_i = 0; brk_tx_i = 0; idpar_err_i = 0; csum_err_i = 0; rsp_err_i = 0;
    id_match_i = 0; ext_bit_i = 0; wr_en_i = 0; wr_data_i = '0;
  endtask

  // inputs applied on the falling edge are captured at the next rising edge
  task automatic step();
    @(posedge clk); #1;
    idle_pulses();
    @(negedge clk);
  endtask

  task automatic clear_all();
    wr_en_i = 1; wr_data_i = '1;
    step();
  endtask

  task automatic t_reset();
    rst = 1; idle_pulses();
    tx_busy_i = 1; rx_busy_i = 1; par_err_i = 1;
    lin_en_i = 0; auto_baud_i = 0; cmp_en_i = 0; ext_en_i = 0; rx_mode_i = 2'b00;
    tx_byte_i = 0; rx_byte_i = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 status", status_o, 0);
    chk("R1 irq", irq_o, 0);
    tx_busy_i = 0; rx_busy_i = 0; par_err_i = 0;
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_plain();
    par_err_i = 1; step();
    chk("R2 parity bit0", status_o, 12'h001);
    chk("R10 irq on new flag", irq_o, 1);
    @(posedge clk); #1;
    chk("R10 irq one cycle", irq_o, 0);
    chk("R11 hold", status_o, 12'h001);
    @(negedge clk);
    frm_err_i = 1; ovr_err_i = 1; step();
    chk("R2 framing+overrun", status_o, 12'h007);
    clear_all();
  endtask

  task automatic t_cmp();
    lin_en_i = 1; cmp_en_i = 1;
    cmp_strobe_i = 1; tx_byte_i = 8'h5A; rx_byte_i = 8'h5A; step();
    chk("R3 equal bytes", status_o, 0);
    cmp_en_i = 0; cmp_strobe_i = 1; rx_byte_i = 8'h5B; step();
    chk("R3 check disabled", status_o, 0);
    cmp_en_i = 1; lin_en_i = 0; cmp_strobe_i = 1; step();
    chk("R3 not LIN", status_o, 0);
    lin_en_i = 1; cmp_strobe_i = 1; step();
    chk("R3 mismatch bit3", status_o, 12'h008);
    cmp_en_i = 0; clear_all();
  endtask

  task automatic t_brk();
    lin_en_i = 1; rx_mode_i = 2'b01; brk_rx_i = 1; step();
    chk("R4 wrong mode", status_o, 0);
    rx_mode_i = 2'b10; lin_en_i = 0; brk_rx_i = 1; step();
    chk("R4 not LIN", status_o, 0);
    lin_en_i = 1; brk_tx_i = 1; step();
    chk("R4 master break bit4", status_o, 12'h010);
    clear_all();
    brk_rx_i = 1; step();
    chk("R4 received break bit4", status_o, 12'h010);
    rx_mode_i = 2'b00; clear_all();
  endtask

  task automatic t_abr();
    lin_en_i = 1; auto_baud_i = 0;
    idpar_err_i = 1; csum_err_i = 1; rsp_err_i = 1; step();
    chk("R5 no auto baud", status_o, 0);
    lin_en_i = 0; auto_baud_i = 1;
    idpar_err_i = 1; csum_err_i = 1; rsp_err_i = 1; step();
    chk("R5 not LIN", status_o, 0);
    lin_en_i = 1;
    idpar_err_i = 1; csum_err_i = 1; rsp_err_i = 1; step();
    chk("R5 bits 5..7", status_o, 12'h0E0);
    auto_baud_i = 0; lin_en_i = 0; clear_all();
  endtask

  task automatic t_ext();
    ext_en_i = 0; id_match_i = 1; ext_bit_i = 1; step();
    chk("R6 disabled", status_o, 0);
    chk("R10 no irq when gated", irq_o, 0);
    ext_en_i = 1; id_match_i = 1; ext_bit_i = 1; step();
    chk("R6 bits 8,9", status_o, 12'h300);
    ext_en_i = 0; clear_all();
  endtask

  task automatic t_w1c();
    par_err_i = 1; frm_err_i = 1; ovr_err_i = 1; step();
    wr_en_i = 1; wr_data_i = 10'h002; step();
    chk("R7 clear only bit1", status_o, 12'h005);
    wr_en_i = 0; wr_data_i = 10'h3FF; step();
    chk("R7 no strobe no clear", status_o, 12'h005);
    par_err_i = 1; step();
    chk("R10 repeat source no irq", irq_o, 0);
    wr_en_i = 1; wr_data_i = 10'h001; ovr_err_i = 1; step();
    chk("R8 set wins (bit2 kept, bit0 cleared)", status_o, 12'h004);
    wr_en_i = 1; wr_data_i = 10'h004; ovr_err_i = 1; step();
    chk("R8 set beats clear same bit", status_o, 12'h004);
    clear_all();
    chk("R7 all cleared", status_o, 0);
  endtask

  task automatic t_busy();
    tx_busy_i = 1; step();
    chk("R9 tx busy bit10", status_o, 12'h400);
    chk("R9 busy no irq", irq_o, 0);
    rx_busy_i = 1; wr_en_i = 1; wr_data_i = '1; step();
    chk("R9 write ignored", status_o, 12'hC00);
    tx_busy_i = 0; rx_busy_i = 0; step();
    chk("R9 busy drops", status_o, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_plain();
    t_cmp();
    t_brk();
    t_abr();
    t_ext();
    t_w1c();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule